// File: doc/BRIEF.md
# Reset and Interrupt Vector Fetch Unit

This unit sits in front of a processor's program counter and loads it when reset or an interrupt is taken. It uses a table of 32-bit target addresses that starts at a configurable word address, `TABLE_BASE`, which defaults to zero. The reset entry comes first. Interrupt line k uses the entry k+1 words above the base. Each entry holds an address and not an instruction. The word read from the table goes into the program counter unchanged, and fetching resumes from there.

A pin-level select, `boot_sel`, decides where each vector read goes. When it is high, the read goes to the internal boot memory port. When it is low, the read goes to the external memory port. Each port uses a request/valid handshake, and the unit waits for valid as long as it takes. Once the word is accepted, a fixed three-cycle delay follows. Then `pc_load` pulses for one cycle with the new value on `pc_value`, and `irq_ack` names the interrupt line that was served.

The controller has four states:
- IDLE waits for work. The transition "take" fires when a reset request or an interrupt is pending.
- READ holds the request. The transition "hit" fires when the selected port answers.
- HOLD counts the delay. The transition "ripe" fires when the counter finishes.
- LOAD lasts one cycle and presents the new PC. The transition "done" returns to IDLE.

Reset is non-maskable: a reset request is remembered until it is served.

Top module: `vec_fetch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_value` is 0, and `pc_load`, `rom_req` and `ext_req` are low. After release, the first vector read is the reset entry at `TABLE_BASE`, and the first load delivers that word.
- R2: The reset entry is at address `TABLE_BASE` + 0. Interrupt line k (bit k of `irq`, counted from 0) reads address `TABLE_BASE` + 1 + k.
- R3: `pc_value` equals the returned word, unmodified. It changes only in a `pc_load` cycle and keeps its value afterwards.
- R4: If the vector word is accepted in cycle c, `pc_load` is high in cycle c+3 and only then, for exactly one cycle.
- R5: A request and its address stay steady for any number of cycles until the selected port raises valid.
- R6: `boot_sel` is sampled when a request is taken: 1 selects the rom port, 0 selects the ext port. The other port's request stays low, and its valid and data are ignored. A later change of `boot_sel` does not move a fetch that is already in progress.
- R7: In an idle cycle, a reset request (pending, or arriving in that cycle on `rst_req`) wins. Otherwise the lowest-numbered asserted `irq` line wins. Requests seen during a fetch wait for the next idle cycle.
- R8: A one-cycle `rst_req` that arrives during a fetch is kept. It is served directly after the current load, ahead of any interrupt.
- R9: During `pc_load`, `irq_ack` has bit k high only if line k was served, and is all zero for a reset. Outside `pc_load`, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; on release, a reset fetch is pending |
| rst_req | input | 1 | Synchronous non-maskable reset request |
| irq | input | NUM_IRQ | Level interrupt lines, bit 0 highest priority |
| boot_sel | input | 1 | 1: vector reads to internal boot memory, 0: to external memory |
| rom_req | output | 1 | Read request to internal boot memory |
| rom_addr | output | AW | Word address for internal boot memory |
| rom_valid | input | 1 | Internal memory data valid |
| rom_data | input | DW | Internal memory read data |
| ext_req | output | 1 | Read request to external memory |
| ext_addr | output | AW | Word address for external memory |
| ext_valid | input | 1 | External memory data valid |
| ext_data | input | DW | External memory read data |
| pc_value | output | DW | Program counter value last loaded |
| pc_load | output | 1 | One-cycle strobe: `pc_value` is the new PC |
| irq_ack | output | NUM_IRQ | One-hot acknowledge of the served line during `pc_load` |

## Verification
Two functions can fall in the same cycle: taking a reset request and taking an interrupt. The bench provokes this twice:
- It raises `rst_req` in the same idle cycle as an interrupt line, which checks that the reset entry is fetched first and that the interrupt follows.
- It pulses `rst_req` while an interrupt fetch is waiting on a slow port, which checks that the interrupt load completes and the reset load comes straight after it.

A behavioural model compares every output on every clock, and a queue of expected load words judges the order in which the loads occur.

// File: rtl/vfu_pkg.sv
`timescale 1ns/1ps
package vfu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_HOLD,
        ST_LOAD
    } vfu_state_e;
endpackage

// File: rtl/vfu_arbiter.sv
`timescale 1ns/1ps
module vfu_arbiter #(
    parameter int NUM_IRQ = 4,
    parameter int IDX_W   = $clog2(NUM_IRQ + 1)
) (
    input  logic               rst_take,
    input  logic [NUM_IRQ-1:0] irq,
    output logic               grant,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        grant = rst_take | (|irq);
        idx   = '0;
        if (!rst_take) begin
            for (int k = NUM_IRQ - 1; k >= 0; k--) begin
                if (irq[k]) begin
                    idx = IDX_W'(k + 1);
                end
            end
        end
    end
endmodule

// File: rtl/vfu_delay.sv
`timescale 1ns/1ps
module vfu_delay #(
    parameter int FETCH_DELAY = 3,
    parameter int CW          = $clog2(FETCH_DELAY)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(FETCH_DELAY - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == CW'(1));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0));
endmodule

// File: rtl/vfu_port_mux.sv
`timescale 1ns/1ps
module vfu_port_mux #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    output logic          rom_req,
    output logic [AW-1:0] rom_addr,
    input  logic          rom_valid,
    input  logic [DW-1:0] rom_data,
    output logic          ext_req,
    output logic [AW-1:0] ext_addr,
    input  logic          ext_valid,
    input  logic [DW-1:0] ext_data,
    output logic          hit,
    output logic [DW-1:0] word
);
    always_comb begin
        rom_req  = active & sel;
        ext_req  = active & ~sel;
        rom_addr = addr;
        ext_addr = addr;
        hit      = sel ? (rom_req & rom_valid) : (ext_req & ext_valid);
        word     = sel ? rom_data : ext_data;
    end

    // R5
    rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && !rom_valid) |=> (rom_req && $stable(rom_addr)));
    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_valid) |=> (ext_req && $stable(ext_addr)));
endmodule

// File: rtl/vec_fetch_unit.sv
`timescale 1ns/1ps
module vec_fetch_unit
    import vfu_pkg::*;
#(
    parameter int          NUM_IRQ     = 4,
    parameter int          AW          = 32,
    parameter int          DW          = 32,
    parameter int unsigned TABLE_BASE  = 0,
    parameter int          FETCH_DELAY = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic               boot_sel,
    output logic               rom_req,
    output logic [AW-1:0]      rom_addr,
    input  logic               rom_valid,
    input  logic [DW-1:0]      rom_data,
    output logic               ext_req,
    output logic [AW-1:0]      ext_addr,
    input  logic               ext_valid,
    input  logic [DW-1:0]      ext_data,
    output logic [DW-1:0]      pc_value,
    output logic               pc_load,
    output logic [NUM_IRQ-1:0] irq_ack
);
    localparam int IDX_W = $clog2(NUM_IRQ + 1);

    vfu_state_e       state_q, state_d;
    logic             sel_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    word_q;
    logic [DW-1:0]    pc_q;
    logic             rst_pend_q;

    logic             rst_take, grant, hit, ripe;
    logic [IDX_W-1:0] idx_pick;
    logic [DW-1:0]    word_in;
    logic [AW-1:0]    vec_addr;

    assign rst_take = rst_pend_q | rst_req;
    assign vec_addr = AW'(TABLE_BASE) + AW'(idx_q);

    vfu_arbiter #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_arb (
        .rst_take (rst_take),
        .irq      (irq),
        .grant    (grant),
        .idx      (idx_pick)
    );

    vfu_port_mux #(.AW(AW), .DW(DW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_READ),
        .sel       (sel_q),
        .addr      (vec_addr),
        .rom_req   (rom_req),
        .rom_addr  (rom_addr),
        .rom_valid (rom_valid),
        .rom_data  (rom_data),
        .ext_req   (ext_req),
        .ext_addr  (ext_addr),
        .ext_valid (ext_valid),
        .ext_data  (ext_data),
        .hit       (hit),
        .word      (word_in)
    );

    vfu_delay #(.FETCH_DELAY(FETCH_DELAY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start ((state_q == ST_READ) && hit),
        .done  (ripe)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (grant) state_d = ST_READ;
            ST_READ: if (hit)   state_d = ST_HOLD;
            ST_HOLD: if (ripe)  state_d = ST_LOAD;
            ST_LOAD:            state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_q      <= 1'b0;
            idx_q      <= '0;
            word_q     <= '0;
            pc_q       <= '0;
            rst_pend_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            rst_pend_q <= rst_take && (state_q != ST_IDLE);
            if (state_q == ST_IDLE && grant) begin
                sel_q <= boot_sel;
                idx_q <= idx_pick;
            end
            if (state_q == ST_READ && hit) begin
                word_q <= word_in;
            end
            if (state_q == ST_HOLD && ripe) begin
                pc_q <= word_q;
            end
        end
    end

    // outputs
    always_comb begin
        pc_value = pc_q;
        pc_load  = (state_q == ST_LOAD);
        for (int k = 0; k < NUM_IRQ; k++) begin
            irq_ack[k] = pc_load && (idx_q == IDX_W'(k + 1));
        end
    end

    // R4
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);
    // R3
    pc_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_value) |-> pc_load);
    // R9
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));
    // R9
    ack_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> pc_load);
    // R8
    rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && state_q != ST_IDLE) |=> rst_pend_q);
    // R7
    rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rst_take) |=> (idx_q == '0));
endmodule

// File: tb/sim_vec_fetch_unit.sv
`timescale 1ns/1ps
module sim_vec_fetch_unit;
    localparam int NI = 4;
    localparam int D  = 3;

    logic          clk = 1'b0;
    logic          rst_n, rst_req, boot_sel;
    logic [NI-1:0] irq;
    logic          rom_req, ext_req, rom_valid, ext_valid, pc_load;
    logic [31:0]   rom_addr, ext_addr, rom_data, ext_data, pc_value;
    logic [NI-1:0] irq_ack;

    int checks = 0;
    int errors = 0;
    int rom_lat = 0, ext_lat = 0, rom_wait = 0, ext_wait = 0;
    logic spur_rom = 0, spur_ext = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // reference model state
    int          m_st;
    int          m_src;
    int          m_left;
    logic        m_sel, m_pend;
    logic [31:0] m_word, m_pc;

    always #2.5 clk = ~clk;

    vec_fetch_unit #(.NUM_IRQ(NI), .FETCH_DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq), .boot_sel(boot_sel),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid), .rom_data(rom_data),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_valid(ext_valid), .ext_data(ext_data),
        .pc_value(pc_value), .pc_load(pc_load), .irq_ack(irq_ack)
    );

    function automatic logic [31:0] rom_word(input logic [31:0] a);
        return 32'hB000_0100 + a * 32'h0001_1111;
    endfunction
    function automatic logic [31:0] ext_word(input logic [31:0] a);
        return 32'hE000_0200 + a * 32'h0002_0303;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 1; m_pc = 0; m_src = 0; m_sel = 0; m_left = 0; m_word = 0;
        end else begin
            logic take;
            take = m_pend | rst_req;
            case (m_st)
                0: begin
                    m_pend = 0;
                    if (take) begin
                        m_st = 1; m_src = 0; m_sel = boot_sel;
                    end else if (irq != 0) begin
                        m_st = 1; m_sel = boot_sel;
                        for (int k = NI - 1; k >= 0; k--) if (irq[k]) m_src = k + 1;
                    end
                end
                1: begin
                    m_pend = take;
                    if (m_sel ? rom_valid : ext_valid) begin
                        m_word = m_sel ? rom_data : ext_data;
                        m_left = D - 1;
                        m_st = 2;
                    end
                end
                2: begin
                    m_pend = take;
                    m_left--;
                    if (m_left == 0) begin m_st = 3; m_pc = m_word; end
                end
                default: begin m_pend = take; m_st = 0; end
            endcase
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            logic [NI-1:0] e_ack;
            e_ack = '0;
            if (m_st == 3 && m_src != 0) e_ack[m_src-1] = 1'b1;
            chk("R6 rom_req", 32'(rom_req), 32'(m_st == 1 && m_sel));
            chk("R6 ext_req", 32'(ext_req), 32'(m_st == 1 && !m_sel));
            if (m_st == 1) chk("R2 vector address", m_sel ? rom_addr : ext_addr, 32'(m_src));
            chk("R4 pc_load timing", 32'(pc_load), 32'(m_st == 3));
            chk("R3 pc_value", pc_value, m_pc);
            chk("R9 irq_ack", 32'(irq_ack), 32'(e_ack));
            if (pc_load) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected load", pc_value, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] w;
                    string t;
                    w = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " load order"}, pc_value, w);
                end
            end
        end
    end

    // memory responders and interrupt source
    always @(negedge clk) begin
        if (rom_req) begin
            if (rom_wait >= rom_lat) begin
                rom_valid = 1'b1; rom_data = rom_word(rom_addr);
            end else begin
                rom_valid = 1'b0; rom_wait++;
            end
        end else begin
            rom_valid = spur_rom; rom_data = 32'hDEAD_0001; rom_wait = 0;
        end
        if (ext_req) begin
            if (ext_wait >= ext_lat) begin
                ext_valid = 1'b1; ext_data = ext_word(ext_addr);
            end else begin
                ext_valid = 1'b0; ext_wait++;
            end
        end else begin
            ext_valid = spur_ext; ext_data = 32'hDEAD_0002; ext_wait = 0;
        end
        if (pc_load === 1'b1) irq = irq & ~irq_ack;
    end

    task automatic expect_load(input logic [31:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; rst_req = 0; irq = '0; boot_sel = 1'b1;
        rom_valid = 0; ext_valid = 0; rom_data = '0; ext_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc_value in reset", pc_value, 32'h0);
        chk("R1 pc_load in reset", 32'(pc_load), 32'h0);
        chk("R1 requests in reset", 32'({rom_req, ext_req}), 32'h0);
        expect_load(rom_word(0), "R1");
        rst_n = 1;
        drain();

        // R6 external port chosen, rom valid noise ignored, select change mid-fetch
        boot_sel = 1'b0; ext_lat = 5; spur_rom = 1'b1;
        expect_load(ext_word(1), "R6");
        irq = 4'b0001;
        repeat (2) @(negedge clk);
        boot_sel = 1'b1;
        drain();
        spur_rom = 1'b0;

        // R7 two lines together: lowest first; R2 last table entry
        rom_lat = 2;
        expect_load(rom_word(2), "R7");
        expect_load(rom_word(4), "R2");
        irq = 4'b1010;
        drain();

        // R7 reset request and interrupt in the same idle cycle
        rom_lat = 0;
        expect_load(rom_word(0), "R7");
        expect_load(rom_word(3), "R7");
        rst_req = 1'b1; irq = 4'b0100;
        @(negedge clk);
        rst_req = 1'b0;
        drain();

        // R8 reset pulse during a slow external fetch, with a waiting interrupt
        boot_sel = 1'b0; ext_lat = 3; spur_ext = 1'b0;
        expect_load(ext_word(1), "R8");
        expect_load(rom_word(0), "R8");
        expect_load(rom_word(2), "R8");
        irq = 4'b0001;
        @(negedge clk);
        boot_sel = 1'b1; irq = 4'b0011;
        @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        drain();

        // R5 long wait for valid, ext valid noise ignored
        rom_lat = 40; spur_ext = 1'b1;
        expect_load(rom_word(4), "R5");
        irq = 4'b1000;
        drain();
        spur_ext = 1'b0;

        chk("R7 all loads seen", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule